// File: doc/BRIEF.md
# Command-Register MDIO Management Master

This block drives a PHY management bus (MDC clock plus a shared MDIO data line) from one 32-bit command/status word. Software puts an operation code, a PHY address, a register address and, for a write, sixteen data bits into the word, then sets a start bit. The block sends a Clause 22 management frame and clears the start bit when the frame is over. For a read, the sixteen bits returned by the PHY replace the low half of the same word. A read in which no PHY pulls the line low during the turnaround raises a fail flag.

MDC is the system clock divided by an even parameter and runs all the time. The master changes MDIO just after each falling MDC edge and samples the line on each rising edge. It releases the line (`mdio_oe` low) for the turnaround and data part of a read. A write can load the fields and the start bit together, or load the fields first and start with a later write that sets only the start bit. Any write that arrives while a transaction is still running is ignored.

Top module: `mdio_cmd_master`

## Requirements
- R1: Bit 29 of the command word is start/busy. A write with bit 29 set and no transaction running launches a frame, and bit 29 reads 1 until the frame ends. It reads 0 from the cycle after the frame's last falling MDC edge.
- R2: Bits 27:26 hold the operation. 2'b10 is a read, in which the master releases MDIO from the turnaround onward. 2'b01 is a write, in which the master drives all 64 bits.
- R3: Bits 25:21 hold the 5-bit PHY address and bits 20:16 hold the 5-bit register address. Both are sent MSB first and read back unchanged.
- R4: A frame is 64 bits long, in this order: 32 ones, the start pattern 0 then 1, the operation (2 bits), the PHY address, the register address, a 2-bit turnaround (1 then 0 on a write), and 16 data bits (bits 15:0 of the word, MSB first).
- R5: MDC is the clock divided by CLK_DIV, with CLK_DIV/2 clock cycles high and CLK_DIV/2 clock cycles low. MDC is 0 in reset.
- R6: MDIO and its output enable change only on a falling MDC edge. MDIO input is sampled on the rising edge.
- R7: During a read, `mdio_oe` is 0 for frame bits 46 to 63. During a write, the turnaround bits are driven as 1 then 0.
- R8: After a read in which bit 47 samples low, bits 15:0 hold the 16 sampled data bits (MSB first) and bit 28 is 0.
- R9: If bit 47 of a read samples high, bit 28 becomes 1 and bits 15:0 read 16'hFFFF. Every accepted write clears bit 28.
- R10: A write with bit 29 set and bits 27:0 all zero starts a frame with the fields loaded before. Any other write loads bits 27:0, and starts a frame only if bit 29 is set.
- R11: A write while bit 29 reads 1 changes no field, and it does not start a second frame.
- R12: After reset the word reads 0, MDC is 0 and `mdio_oe` is 0. `mdio_oe` is 0 whenever no frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Write data for the command word |
| reg_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO line value as seen by the master |

## Verification
The hardest case to reach is a command write that lands in the middle of a running frame. It has to arrive between two MDC edges without disturbing the bench's tracking of the frame bits. The bench follows each frame bit by bit at the MDC edges and injects that write right after the sample of bit 10. It then checks three things: the remaining bits of the frame, the fields that read back afterwards, and an idle line with no second launch. The fail path is reached by leaving the line pulled high during a read, and the following good read shows that the flag clears.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

   // command word bit positions
   localparam int CMD_W    = 32;
   localparam int BUSY_BIT = 29;
   localparam int FAIL_BIT = 28;
   localparam int OP_LO    = 26;
   localparam int OP_W     = 2;
   localparam int ADDR_W   = 5;
   localparam int DATA_W   = 16;

   localparam logic [OP_W-1:0] OPC_WRITE = 2'b01;
   localparam logic [OP_W-1:0] OPC_READ  = 2'b10;

   // bits of the frame that follow the preamble
   localparam int BODY_BITS = 2 + OP_W + 2 * ADDR_W + 2 + DATA_W;

   typedef struct packed {
      logic [OP_W-1:0]   op;
      logic [ADDR_W-1:0] phy;
      logic [ADDR_W-1:0] regad;
      logic [DATA_W-1:0] data;
   } mdio_cmd_t;

endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
   parameter int DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);
   localparam int HALF = DIV / 2;
   localparam int CW   = $clog2(DIV);

   generate
      if (DIV < 4 || (DIV % 2) != 0) begin : g_bad_div
         $error("mdio_mdc_div: DIV must be even and at least 4");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign rise_stb = (cnt == CW'(HALF - 1));
   assign fall_stb = (cnt == CW'(DIV - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else begin
         cnt <= fall_stb ? '0 : cnt + 1'b1;
         if (rise_stb)
            mdc <= 1'b1;
         else if (fall_stb)
            mdc <= 1'b0;
      end
   end

   // checker: length of each high phase
   logic [CW:0] hi_len;
   always_ff @(posedge clk) begin
      if (!rst_n) hi_len <= '0;
      else        hi_len <= mdc ? hi_len + 1'b1 : '0;
   end

   assert_mdc_high_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdc) |-> (hi_len == (CW+1)'(HALF)));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_cmd_pkg::*;
#(
   parameter int PREAMBLE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  mdio_cmd_t         launch_cmd,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              mdio_i,
   output logic              busy,
   output logic              done,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_fail
);
   localparam int FRAME_LEN = PREAMBLE_LEN + BODY_BITS;
   localparam int IW        = $clog2(FRAME_LEN + 1);
   localparam int TA_IDX    = PREAMBLE_LEN + 2 + OP_W + 2 * ADDR_W;
   localparam int DATA_IDX  = TA_IDX + 2;
   localparam int LAST_IDX  = FRAME_LEN - 1;

   generate
      if (PREAMBLE_LEN < 1) begin : g_bad_pre
         $error("mdio_frame_engine: PREAMBLE_LEN must be at least 1");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_ALIGN, ST_SHIFT} eng_state_t;

   eng_state_t             state;
   logic [FRAME_LEN-1:0]   shreg;
   logic [IW-1:0]          idx;
   logic [IW-1:0]          nxt_idx;
   logic                   is_rd;
   logic                   ta_ok;
   logic [DATA_W-1:0]      rx;
   logic [FRAME_LEN-1:0]   frame_w;
   logic                   launch_rd;

   assign launch_rd = (launch_cmd.op == OPC_READ);
   assign frame_w   = {{PREAMBLE_LEN{1'b1}}, 2'b01, launch_cmd.op, launch_cmd.phy,
                       launch_cmd.regad, (launch_rd ? 2'b11 : 2'b10),
                       (launch_rd ? {DATA_W{1'b1}} : launch_cmd.data)};
   assign nxt_idx   = idx + 1'b1;

   assign busy    = (state != ST_IDLE);
   assign done    = (state == ST_SHIFT) && fall_stb && (idx == IW'(LAST_IDX));
   assign rd_fail = !ta_ok;
   assign rd_data = ta_ok ? rx : {DATA_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         shreg   <= '0;
         idx     <= '0;
         is_rd   <= 1'b0;
         ta_ok   <= 1'b0;
         rx      <= '0;
         mdio_o  <= 1'b1;
         mdio_oe <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (launch) begin
                  state <= ST_ALIGN;
                  shreg <= frame_w;
                  is_rd <= launch_rd;
                  ta_ok <= 1'b0;
               end
            end
            ST_ALIGN: begin
               if (fall_stb) begin
                  state   <= ST_SHIFT;
                  idx     <= '0;
                  mdio_o  <= shreg[FRAME_LEN-1];
                  mdio_oe <= 1'b1;
                  shreg   <= shreg << 1;
               end
            end
            default: begin
               if (rise_stb && is_rd) begin
                  if (idx == IW'(TA_IDX + 1))
                     ta_ok <= !mdio_i;
                  if (idx >= IW'(DATA_IDX))
                     rx <= {rx[DATA_W-2:0], mdio_i};
               end
               if (fall_stb) begin
                  if (idx == IW'(LAST_IDX)) begin
                     state   <= ST_IDLE;
                     mdio_o  <= 1'b1;
                     mdio_oe <= 1'b0;
                  end else begin
                     idx     <= nxt_idx;
                     mdio_o  <= shreg[FRAME_LEN-1];
                     mdio_oe <= !(is_rd && (nxt_idx >= IW'(TA_IDX)));
                     shreg   <= shreg << 1;
                  end
               end
            end
         endcase
      end
   end

   assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT && is_rd && idx >= IW'(TA_IDX)) |-> !mdio_oe);

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !mdio_oe);

endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
   import mdio_cmd_pkg::*;
#(
   parameter int CLK_DIV      = 50,
   parameter int PREAMBLE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr_en,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   mdio_cmd_t         cmd_q;
   mdio_cmd_t         wr_cmd;
   mdio_cmd_t         launch_cmd;
   logic              fail_q;
   logic              eng_busy;
   logic              eng_done;
   logic [DATA_W-1:0] eng_rd_data;
   logic              eng_rd_fail;
   logic              rise_stb;
   logic              fall_stb;
   logic              accept;
   logic              start_only;
   logic              launch;
   logic              unused_wbits;

   assign unused_wbits = ^{reg_wdata[31:30], reg_wdata[FAIL_BIT]};

   assign wr_cmd     = reg_wdata[OP_LO+OP_W-1:0];
   assign accept     = reg_wr_en && !eng_busy;
   assign start_only = reg_wdata[BUSY_BIT] && (reg_wdata[OP_LO+OP_W-1:0] == '0);
   assign launch     = accept && reg_wdata[BUSY_BIT];
   assign launch_cmd = start_only ? cmd_q : wr_cmd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         fail_q <= 1'b0;
      end else if (accept) begin
         cmd_q  <= launch_cmd;
         fail_q <= 1'b0;
      end else if (eng_done && cmd_q.op == OPC_READ) begin
         cmd_q.data <= eng_rd_data;
         fail_q     <= eng_rd_fail;
      end
   end

   assign reg_rdata = {2'b00, eng_busy, fail_q, cmd_q};

   mdio_mdc_div #(.DIV(CLK_DIV)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_frame_engine #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .launch_cmd (launch_cmd),
      .rise_stb   (rise_stb),
      .fall_stb   (fall_stb),
      .mdio_i     (mdio_i),
      .busy       (eng_busy),
      .done       (eng_done),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe),
      .rd_data    (eng_rd_data),
      .rd_fail    (eng_rd_fail)
   );

   assert_busy_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eng_busy) |-> $past(eng_done));

   assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && reg_wr_en) |=> $stable(reg_rdata[27:16]));

   assert_fail_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[FAIL_BIT] |-> (reg_rdata[15:0] == 16'hFFFF));

   assert_mdio_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({mdio_o, mdio_oe}) |-> $fell(mdc));

endmodule

// File: tb/test_mdio_cmd_master.sv
module test_mdio_cmd_master;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc;
   logic        mdio_o;
   logic        mdio_oe;
   logic        mdio_i = 1'b1;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // reference model of the command word
   logic [1:0]  m_op = '0;
   logic [4:0]  m_phy = '0;
   logic [4:0]  m_reg = '0;
   logic [15:0] m_data = '0;
   logic        m_fail = 1'b0;

   always #4 clk = ~clk;

   mdio_cmd_master #(.CLK_DIV(DIV)) i_mdio_cmd_master (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr_en (reg_wr_en),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .mdc       (mdc),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .mdio_i    (mdio_i)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_word();
      return {2'b00, 1'b0, m_fail, m_op, m_phy, m_reg, m_data};
   endfunction

   task automatic raw_wr(input logic [31:0] w);
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_wdata = w;
      @(negedge clk);
      reg_wr_en = 1'b0;
      reg_wdata = '0;
   endtask

   // accepted write: model follows the load rules of R10
   task automatic wr(input logic [31:0] w);
      if (!(w[29] && w[27:0] == '0)) begin
         m_op   = w[27:26];
         m_phy  = w[25:21];
         m_reg  = w[20:16];
         m_data = w[15:0];
      end
      m_fail = 1'b0;
      raw_wr(w);
   endtask

   task automatic follow_frame(input bit phy_on, input logic [15:0] pv,
                               input bit poke, input logic [31:0] poke_w);
      bit rd;
      logic [63:0] f;
      int t;
      rd = (m_op == 2'b10);
      f = {32'hFFFF_FFFF, 2'b01, m_op, m_phy, m_reg,
           (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : m_data)};
      chk("R1 busy set", {31'b0, reg_rdata[29]}, 32'd1);
      t = 0;
      while (!mdio_oe && t < 100) begin
         @(negedge clk);
         t++;
      end
      for (int k = 0; k < 64; k++) begin
         if (k > 0) @(negedge mdc);
         #1;
         if (rd && phy_on)
            mdio_i = (k == 47) ? 1'b0 : (k >= 48 ? pv[63-k] : 1'b1);
         else
            mdio_i = 1'b1;
         @(posedge mdc);
         #1;
         chk($sformatf("R7 oe bit %0d", k), {31'b0, mdio_oe},
             {31'b0, !(rd && k >= 46)});
         if (!(rd && k >= 46))
            chk($sformatf("R4 frame bit %0d", k), {31'b0, mdio_o}, {31'b0, f[63-k]});
         if (poke && k == 10) raw_wr(poke_w);
      end
      mdio_i = 1'b1;
      t = 0;
      while (reg_rdata[29] && t < 100) begin
         @(negedge clk);
         t++;
      end
      if (rd) begin
         m_data = phy_on ? pv : 16'hFFFF;
         m_fail = !phy_on;
      end
      chk(rd ? (phy_on ? "R8 read word" : "R9 fail word") : "R3 write word",
          reg_rdata, model_word());
      chk("R12 oe idle after frame", {31'b0, mdio_oe}, 32'd0);
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int t_hi, t_lo, t_end;
      int oe_seen;
      repeat (5) @(negedge clk);
      chk("R12 reset word", reg_rdata, 32'd0);
      chk("R12 reset mdc", {31'b0, mdc}, 32'd0);
      chk("R12 reset oe", {31'b0, mdio_oe}, 32'd0);
      rst_n = 1'b1;

      // R5 period and duty
      @(posedge mdc); t_hi = $time;
      @(negedge mdc); t_lo = $time;
      @(posedge mdc); t_end = $time;
      chk("R5 high time", t_lo - t_hi, (DIV / 2) * 8);
      chk("R5 period", t_end - t_hi, DIV * 8);

      // R2 write, fields and start in one word
      wr({2'b00, 1'b1, 1'b0, 2'b01, 5'h05, 5'h11, 16'hA5C3});
      follow_frame(1'b0, 16'h0, 1'b0, 32'h0);

      // R8 read with a PHY answering
      wr({2'b00, 1'b1, 1'b0, 2'b10, 5'h1F, 5'h00, 16'h0000});
      follow_frame(1'b1, 16'h1234, 1'b0, 32'h0);

      // R9 read with nobody driving the turnaround
      wr({2'b00, 1'b1, 1'b0, 2'b10, 5'h02, 5'h03, 16'h0000});
      follow_frame(1'b0, 16'h0, 1'b0, 32'h0);
      chk("R9 fail flag", {31'b0, reg_rdata[28]}, 32'd1);

      // R8 next read clears the flag
      wr({2'b00, 1'b1, 1'b0, 2'b10, 5'h02, 5'h03, 16'h0000});
      follow_frame(1'b1, 16'hBEEF, 1'b0, 32'h0);
      chk("R8 fail cleared", {31'b0, reg_rdata[28]}, 32'd0);

      // R10 fields first, start bit later
      wr({2'b00, 1'b0, 1'b0, 2'b10, 5'h07, 5'h02, 16'h0000});
      chk("R10 fields loaded no start", reg_rdata, model_word());
      oe_seen = 0;
      repeat (3 * DIV) begin
         @(negedge clk);
         if (mdio_oe) oe_seen++;
      end
      chk("R10 no launch without start", oe_seen, 0);
      wr(32'h2000_0000);
      follow_frame(1'b1, 16'hC0DE, 1'b0, 32'h0);

      // R11 write during a running frame
      wr({2'b00, 1'b1, 1'b0, 2'b01, 5'h03, 5'h04, 16'h0F0F});
      follow_frame(1'b0, 16'h0, 1'b1, {2'b00, 1'b1, 1'b0, 2'b10, 5'h0A, 5'h0B, 16'h5555});
      oe_seen = 0;
      repeat (4 * DIV) begin
         @(negedge clk);
         if (mdio_oe || reg_rdata[29]) oe_seen++;
      end
      chk("R11 no second frame", oe_seen, 0);
      chk("R11 fields kept", reg_rdata, model_word());

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule